// File: doc/BRIEF.md
# Beat Recorder Sequencing Controller

This controller runs a small heart-beat period recorder through its life cycle. It powers up idle and halted. An external reset starts a clearing pass, in which a zero is written to every memory word, one word per falling edge of a slow clear tick. When the external address counter signals its carry, the controller moves to recording. From then on it stores one beat period for each storage request. A storage request is raised every ten seconds by a slow tick. The controller halts when the address counter carries again, meaning memory is full, or when the operator asks it to stop.

The write path is a two-stage pulse generator. A write-enable pulse of fixed length is followed at once by a combined address-increment and counter-preset pulse. The preset half fires on every falling edge of the counting gate, so the beat counter always reloads its offset. The write-enable and increment halves pass only while clearing, or while a request is pending. A request becomes pending when the request flag and the counting gate are both high. An address-reset pulse marks both the start and the end of the clearing pass. The counting gate and the address counter sit outside this block. All inputs are expected to be synchronous to `clk`.

Top module: `beat_recorder_seq`

## Requirements
- R1: After `rst_n` is released, the controller is halted and all five outputs are low.
- R2: `clr_level_o` is high exactly while clearing. A high `ext_reset_i` sampled at a clock edge enters clearing from any state, and wins over `ext_stop_i` when both are high.
- R3: While clearing, with `addr_carry_i` low and the pulse generator idle, a falling edge of `clear_tick_i` makes `wr_en_o` high for WE_CYCLES cycles, starting one cycle after the edge is sampled. `addr_inc_o` and `preset_o` are then high together for STEP_CYCLES cycles, starting in the cycle after `wr_en_o` ends.
- R4: `addr_rst_o` is high for AR_CYCLES cycles, starting in the cycle where `clr_level_o` rises or falls.
- R5: A rising edge of `addr_carry_i` during clearing ends clearing and starts recording. The address reset issued at that moment clears the carry, so this happens once per external reset.
- R6: The request flag is set by a rising edge of `store_tick_i` and cleared while `addr_inc_o` is high; the clear wins. Several ticks before one write still give a single write.
- R7: While recording, a request becomes pending when the flag and `gate_i` are high together, in either order. The next falling edge of `gate_i` then gives exactly one write sequence of the R3 shape.
- R8: A falling edge of `gate_i` while recording, with no pending request, gives a `preset_o` pulse of STEP_CYCLES cycles and no `wr_en_o` or `addr_inc_o`.
- R9: A rising edge of `addr_carry_i` while recording, or a high `ext_stop_i` in any state, enters halt. In halt, `gate_i`, both ticks and `addr_carry_i` produce no output pulse.
- R10: A pending request returns to plain recording as its write-enable pulse ends. The next gate fall without a new tick therefore gives only a preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_i | input | 1 | Counting gate; a falling edge ends a beat measurement |
| store_tick_i | input | 1 | Slow storage tick; a rising edge requests one store |
| clear_tick_i | input | 1 | Clear-rate tick; a falling edge writes one zero word while clearing |
| addr_carry_i | input | 1 | Carry out of the external address counter |
| ext_reset_i | input | 1 | Operator start: clear memory, then record |
| ext_stop_i | input | 1 | Operator stop: enter halt |
| clr_level_o | output | 1 | High while clearing; holds the beat counter at zero |
| addr_rst_o | output | 1 | Address counter reset pulse |
| wr_en_o | output | 1 | Memory write-enable pulse |
| addr_inc_o | output | 1 | Address increment pulse |
| preset_o | output | 1 | Beat counter preset pulse |

## Verification
The bench goes after the carry that is still high when clearing ends. A design that acts on the carry level, rather than its rising edge, halts at once, and the write count of the recording run comes out at zero. It sends ticks while the gate is low, while it is high, and twice within one interval. A controller that latches the request only in one of those orders, or that counts ticks, stores too few or too many words. After each write it sends one gate fall with no new tick, which catches a controller that never leaves the pending state and so writes twice per request. It also holds both operator inputs high together, and drives every input while halted. A wrong priority leaves the recorder halted. A leaky halt shows up as stray preset or write pulses.

// File: rtl/brs_pkg.sv
package brs_pkg;

    // Phase encoding: bit 1 is the "not clearing, writes blocked" half,
    // bit 0 the "recording allowed" half.
    typedef enum logic [1:0] {
        PH_START  = 2'b00,
        PH_ARMED  = 2'b01,
        PH_HALT   = 2'b10,
        PH_RECORD = 2'b11
    } phase_e;

    typedef enum logic [1:0] {
        SHOT_IDLE   = 2'b00,
        SHOT_FIRST  = 2'b01,
        SHOT_SECOND = 2'b10
    } shot_e;

endpackage

// File: rtl/brs_edge.sv
module brs_edge #(
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic edge_o
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    generate
        if (FALLING) begin : g_fall
            assign edge_o = prev_q & ~sig_i;
        end else begin : g_rise
            assign edge_o = sig_i & ~prev_q;
        end
    endgenerate

endmodule

// File: rtl/brs_req_flag.sv
module brs_req_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clear_i,
    output logic flag_o
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clear_i)    flag_d = 1'b0;
        else if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/brs_pulse.sv
module brs_pulse #(
    parameter int LEN = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic pulse_o
);

    localparam int CW = $clog2(LEN + 1);
    typedef logic [CW-1:0] cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (trig_i)             cnt_d = cnt_t'(LEN);
        else if (cnt_q != '0)   cnt_d = cnt_q - cnt_t'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pulse_o = (cnt_q != '0);

endmodule

// File: rtl/brs_two_shot.sv
module brs_two_shot
    import brs_pkg::*;
#(
    parameter int FIRST_LEN  = 500,
    parameter int SECOND_LEN = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic en_i,
    output logic first_o,
    output logic second_o,
    output logic second_raw_o,
    output logic first_last_o
);

    localparam int MAXLEN = (FIRST_LEN > SECOND_LEN) ? FIRST_LEN : SECOND_LEN;
    localparam int CW     = $clog2(MAXLEN + 1);
    typedef logic [CW-1:0] cnt_t;

    typedef struct packed {
        shot_e ph;
        cnt_t  cnt;
        logic  en;
    } shot_t;

    shot_t q, d;

    always_comb begin
        d = q;
        unique case (q.ph)
            SHOT_IDLE: begin
                if (trig_i) begin
                    d.ph  = SHOT_FIRST;
                    d.cnt = cnt_t'(FIRST_LEN - 1);
                    d.en  = en_i;
                end
            end
            SHOT_FIRST: begin
                if (q.cnt == '0) begin
                    d.ph  = SHOT_SECOND;
                    d.cnt = cnt_t'(SECOND_LEN - 1);
                end else begin
                    d.cnt = q.cnt - cnt_t'(1);
                end
            end
            SHOT_SECOND: begin
                if (q.cnt == '0) d.ph  = SHOT_IDLE;
                else             d.cnt = q.cnt - cnt_t'(1);
            end
            default: d.ph = SHOT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: SHOT_IDLE, cnt: '0, en: 1'b0};
        else        q <= d;
    end

    assign first_o      = (q.ph == SHOT_FIRST)  && q.en;
    assign second_raw_o = (q.ph == SHOT_SECOND);
    assign second_o     = (q.ph == SHOT_SECOND) && q.en;
    assign first_last_o = (q.ph == SHOT_FIRST)  && q.en && (q.cnt == '0);

endmodule

// File: rtl/beat_recorder_seq.sv
module beat_recorder_seq
    import brs_pkg::*;
#(
    parameter int WE_CYCLES   = 500,
    parameter int STEP_CYCLES = 500,
    parameter int AR_CYCLES   = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    input  logic store_tick_i,
    input  logic clear_tick_i,
    input  logic addr_carry_i,
    input  logic ext_reset_i,
    input  logic ext_stop_i,
    output logic clr_level_o,
    output logic addr_rst_o,
    output logic wr_en_o,
    output logic addr_inc_o,
    output logic preset_o
);

    typedef struct packed {
        phase_e phase;
    } ctl_t;

    ctl_t q, d;

    logic gate_fall, clear_fall, store_rise, carry_rise;
    logic req_flag;
    logic shot_trig, shot_en, shot_first_last;
    logic ar_trig;
    logic was_clearing, now_clearing;

    brs_edge #(.FALLING(1'b1)) u_gate_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(gate_i), .edge_o(gate_fall)
    );
    brs_edge #(.FALLING(1'b1)) u_clear_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(clear_tick_i), .edge_o(clear_fall)
    );
    brs_edge #(.FALLING(1'b0)) u_store_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(store_tick_i), .edge_o(store_rise)
    );
    brs_edge #(.FALLING(1'b0)) u_carry_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(addr_carry_i), .edge_o(carry_rise)
    );

    brs_req_flag u_flag (
        .clk(clk), .rst_n(rst_n),
        .set_i(store_rise), .clear_i(addr_inc_o),
        .flag_o(req_flag)
    );

    // Phase sequencing
    always_comb begin
        d = q;
        if (ext_reset_i) begin
            d.phase = PH_START;
        end else if (ext_stop_i) begin
            d.phase = PH_HALT;
        end else begin
            unique case (q.phase)
                PH_START:  if (carry_rise) d.phase = PH_RECORD;
                PH_RECORD: begin
                    if (carry_rise)               d.phase = PH_HALT;
                    else if (req_flag && gate_i)  d.phase = PH_ARMED;
                end
                PH_ARMED: begin
                    if (carry_rise)           d.phase = PH_HALT;
                    else if (shot_first_last) d.phase = PH_RECORD;
                end
                default: d.phase = PH_HALT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: PH_HALT};
        else        q <= d;
    end

    // Write pulse generation
    always_comb begin
        shot_trig = ((q.phase == PH_START) && clear_fall && !addr_carry_i) ||
                    (((q.phase == PH_RECORD) || (q.phase == PH_ARMED)) && gate_fall);
        shot_en   = (q.phase == PH_START) || (q.phase == PH_ARMED);
    end

    brs_two_shot #(
        .FIRST_LEN (WE_CYCLES),
        .SECOND_LEN(STEP_CYCLES)
    ) u_shot (
        .clk(clk), .rst_n(rst_n),
        .trig_i(shot_trig), .en_i(shot_en),
        .first_o(wr_en_o), .second_o(addr_inc_o),
        .second_raw_o(preset_o), .first_last_o(shot_first_last)
    );

    // Address reset on both edges of the clearing level
    always_comb begin
        was_clearing = (q.phase == PH_START);
        now_clearing = (d.phase == PH_START);
        ar_trig      = was_clearing ^ now_clearing;
    end

    brs_pulse #(.LEN(AR_CYCLES)) u_ar (
        .clk(clk), .rst_n(rst_n), .trig_i(ar_trig), .pulse_o(addr_rst_o)
    );

    assign clr_level_o = (q.phase == PH_START);

endmodule

// File: rtl/brs_checker.sv
module brs_checker (
    input logic clk,
    input logic rst_n,
    input logic ext_reset_i,
    input logic ext_stop_i,
    input logic clr_level_o,
    input logic addr_rst_o,
    input logic wr_en_o,
    input logic addr_inc_o,
    input logic preset_o
);

    a_r2_reset_enters_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ext_reset_i |=> clr_level_o);

    a_r9_stop_leaves_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_stop_i && !ext_reset_i) |=> !clr_level_o);

    a_r4_ar_on_level_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(clr_level_o) || $fell(clr_level_o)) |-> addr_rst_o);

    a_r3_inc_follows_we: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_en_o) |-> addr_inc_o);

    a_r7_we_inc_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && addr_inc_o));

    a_r8_inc_has_preset: assert property (@(posedge clk) disable iff (!rst_n)
        addr_inc_o |-> preset_o);

endmodule

bind beat_recorder_seq brs_checker chk_i (
    .clk(clk), .rst_n(rst_n),
    .ext_reset_i(ext_reset_i), .ext_stop_i(ext_stop_i),
    .clr_level_o(clr_level_o), .addr_rst_o(addr_rst_o),
    .wr_en_o(wr_en_o), .addr_inc_o(addr_inc_o), .preset_o(preset_o)
);

// File: tb/beat_recorder_seq_tb_top.sv
module beat_recorder_seq_tb_top;

    localparam int WE    = 4;
    localparam int STEP  = 3;
    localparam int AR    = 2;
    localparam int DEPTH = 8;
    localparam int GH    = 20;
    localparam int GL    = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate_i = 1'b0, store_tick_i = 1'b0, clear_tick_i = 1'b0;
    logic ext_reset_i = 1'b0, ext_stop_i = 1'b0;
    logic addr_carry_i;
    logic clr_level_o, addr_rst_o, wr_en_o, addr_inc_o, preset_o;

    always #10 clk = ~clk;

    beat_recorder_seq #(.WE_CYCLES(WE), .STEP_CYCLES(STEP), .AR_CYCLES(AR)) dut_i (
        .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .store_tick_i(store_tick_i),
        .clear_tick_i(clear_tick_i), .addr_carry_i(addr_carry_i),
        .ext_reset_i(ext_reset_i), .ext_stop_i(ext_stop_i),
        .clr_level_o(clr_level_o), .addr_rst_o(addr_rst_o), .wr_en_o(wr_en_o),
        .addr_inc_o(addr_inc_o), .preset_o(preset_o)
    );

    int n_cmp = 0, n_bad = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Environment: external address counter
    int env_addr = 0;
    logic inc_prev = 1'b0;
    assign addr_carry_i = (env_addr == DEPTH);
    always @(posedge clk) begin
        if (addr_rst_o) env_addr <= 0;
        else if (addr_inc_o && !inc_prev) env_addr <= env_addr + 1;
        inc_prev <= addr_inc_o;
    end

    // Pulse counters on DUT outputs
    int we_cnt = 0, pre_cnt = 0;
    logic we_prev = 1'b0, pre_prev = 1'b0;
    always @(posedge clk) begin
        if (wr_en_o && !we_prev)   we_cnt++;
        if (preset_o && !pre_prev) pre_cnt++;
        we_prev  = wr_en_o;
        pre_prev = preset_o;
    end

    // Behavioural reference: 0 clearing, 1 recording, 2 pending, 3 halted
    int m_st = 3, m_left = 0, m_ar = 0;
    bit m_en = 0, m_flag = 0;
    bit pg = 0, pc = 0, ps = 0, pk = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 3; m_left = 0; m_ar = 0; m_en = 0; m_flag = 0;
            pg = 0; pc = 0; ps = 0; pk = 0;
        end else begin
            bit gfall, cfall, srise, krise, inc_now, last_we, trig;
            int nst;
            gfall   = pg && !gate_i;
            cfall   = pc && !clear_tick_i;
            srise   = !ps && store_tick_i;
            krise   = !pk && addr_carry_i;
            inc_now = m_en && (m_left > 0) && (m_left <= STEP);
            last_we = m_en && (m_left == STEP + 1);
            nst = m_st;
            if (ext_reset_i) nst = 0;
            else if (ext_stop_i) nst = 3;
            else if (m_st == 0) begin
                if (krise) nst = 1;
            end else if (m_st == 1) begin
                if (krise) nst = 3;
                else if (m_flag && gate_i) nst = 2;
            end else if (m_st == 2) begin
                if (krise) nst = 3;
                else if (last_we) nst = 1;
            end
            trig = (m_st == 0 && cfall && !addr_carry_i) || ((m_st == 1 || m_st == 2) && gfall);
            if (m_left == 0 && trig) begin
                m_left = WE + STEP;
                m_en = (m_st == 0 || m_st == 2);
            end else if (m_left > 0) m_left--;
            if (inc_now) m_flag = 0;
            else if (srise) m_flag = 1;
            if ((m_st == 0) != (nst == 0)) m_ar = AR;
            else if (m_ar > 0) m_ar--;
            m_st = nst;
            pg = gate_i; pc = clear_tick_i; ps = store_tick_i; pk = addr_carry_i;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", "clr_level", int'(clr_level_o), int'(m_st == 0));
            chk("R4", "addr_rst",  int'(addr_rst_o),  int'(m_ar > 0));
            chk("R3", "wr_en",     int'(wr_en_o),     int'(m_en && m_left > STEP));
            chk("R7", "addr_inc",  int'(addr_inc_o),  int'(m_en && m_left > 0 && m_left <= STEP));
            chk("R8", "preset",    int'(preset_o),    int'(m_left > 0 && m_left <= STEP));
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One beat: gate high GH cycles, then low GL; ticks start at t1/t2 (-1 none)
    task automatic beat(input int t1, input int t2);
        for (int i = 0; i < GH + GL; i++) begin
            @(negedge clk);
            gate_i = (i < GH);
            store_tick_i = (t1 >= 0 && i >= t1 && i < t1 + 3) ||
                           (t2 >= 0 && i >= t2 && i < t2 + 3);
        end
        store_tick_i = 1'b0;
    endtask

    task automatic clear_pass();
        for (int k = 0; k < 20 && !(env_addr == DEPTH); k++) begin
            @(negedge clk); clear_tick_i = 1'b1;
            wait_cyc(5);    clear_tick_i = 1'b0;
            wait_cyc(15);
        end
        wait_cyc(10);
    endtask

    task automatic zero_counts();
        @(negedge clk);
        we_cnt = 0; pre_cnt = 0;
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: halted, outputs low
        chk("R1", "clr_level", int'(clr_level_o), 0);
        chk("R1", "addr_rst",  int'(addr_rst_o),  0);
        chk("R1", "wr_en",     int'(wr_en_o),     0);
        chk("R1", "addr_inc",  int'(addr_inc_o),  0);
        chk("R1", "preset",    int'(preset_o),    0);

        // R9: stimulus while halted is ignored
        zero_counts();
        beat(3, -1);
        chk("R9", "halt writes", we_cnt, 0);
        chk("R9", "halt presets", pre_cnt, 0);

        // R2/R4: operator start
        @(negedge clk); ext_reset_i = 1'b1;
        @(negedge clk); ext_reset_i = 1'b0;
        chk("R2", "start level", int'(clr_level_o), 1);
        chk("R4", "start addr reset", int'(addr_rst_o), 1);

        // R3/R5: clearing pass writes every word once
        zero_counts();
        clear_pass();
        chk("R3", "clear writes", we_cnt, DEPTH);
        chk("R5", "recording after carry", int'(clr_level_o), 0);
        chk("R4", "address back at zero", env_addr, 0);

        // R8: beat without a request
        zero_counts(); beat(-1, -1);
        chk("R8", "plain beat writes", we_cnt, 0);
        chk("R8", "plain beat presets", pre_cnt, 1);

        // R6/R7: tick while gate low, served on next beat
        zero_counts(); beat(GH + 5, -1); beat(-1, -1);
        chk("R7", "tick in gate low", we_cnt, 1);

        // R7: tick while gate high
        zero_counts(); beat(5, -1);
        chk("R7", "tick in gate high", we_cnt, 1);

        // R10: pending cleared after its write
        zero_counts(); beat(-1, -1);
        chk("R10", "no repeat write", we_cnt, 0);
        chk("R10", "preset only", pre_cnt, 1);

        // R6: two ticks in one interval give one write
        zero_counts(); beat(5, 9);
        chk("R6", "double tick", we_cnt, 1);

        // Fill remaining words, then carry halts (R9)
        for (int w = 0; w < DEPTH - 3; w++) begin
            zero_counts(); beat(2, -1);
            chk("R7", "fill write", we_cnt, 1);
        end
        zero_counts(); beat(2, -1); beat(2, -1);
        clear_tick_i = 1'b1; wait_cyc(3); clear_tick_i = 1'b0; wait_cyc(3);
        chk("R9", "full: writes", we_cnt, 0);
        chk("R9", "full: presets", pre_cnt, 0);
        chk("R9", "full: level", int'(clr_level_o), 0);

        // R2: reset wins over stop
        @(negedge clk); ext_reset_i = 1'b1; ext_stop_i = 1'b1;
        @(negedge clk); ext_reset_i = 1'b0; ext_stop_i = 1'b0;
        chk("R2", "reset over stop", int'(clr_level_o), 1);
        zero_counts();
        clear_pass();
        chk("R3", "second clear writes", we_cnt, DEPTH);
        chk("R5", "second recording", int'(clr_level_o), 0);
        zero_counts(); beat(3, -1);
        chk("R7", "record after restart", we_cnt, 1);

        // R9: operator stop
        @(negedge clk); ext_stop_i = 1'b1;
        @(negedge clk); ext_stop_i = 1'b0;
        zero_counts(); beat(3, -1);
        chk("R9", "stopped writes", we_cnt, 0);
        chk("R9", "stopped presets", pre_cnt, 0);

        wait_cyc(5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule